// File: doc/BRIEF.md
# Instrumentation Trace UART Serializer

This block is a small trace source. Software, or any on-chip agent, writes single bytes to a set of numbered stimulus ports. Each byte that is accepted becomes a two-byte packet. The first byte is a header that identifies the port, and the second byte is the payload. Packets wait in a small shared queue. A serializer then sends them one bit at a time on a single line that is framed like a UART and idles high.

A configuration register bus sets up the block. It holds a lock register, a global enable, a per-port enable mask, a bit-period prescaler and a line protocol select. All configuration writes are ignored until the lock register is written with the access key. Each stimulus port has a readiness flag. The flag tells the writer whether the queue can take one more byte, and a write made while the queue is full is lost.

Top module: `itrace_serializer`

## Requirements
- R1: After synchronous reset the line is high, the block is locked, the enable, mask, prescaler and protocol registers read 0, and every stimulus ready flag is 1.
- R2: Register addresses are 0 lock, 1 enable (bit 0), 2 port mask (bit i = port i), 3 prescaler, 4 protocol. Writing 0xC5ACCE55 to address 0 unlocks the block, and writing any other value locks it again. Address 0 reads 1 while locked and 0 while unlocked. Writes to addresses 1 to 4 have no effect while locked.
- R3: Every packet is a header byte equal to (port << 3) | 1, so port 0 gives 0x01 and port 1 gives 0x09. The payload byte follows directly, with no other byte between the two.
- R4: Each byte is framed as one low start bit, eight data bits with the LSB first, and one high stop bit. The line is high whenever nothing is being sent.
- R5: Each bit lasts prescaler+1 clock cycles. A prescaler of 0 gives one cycle per bit.
- R6: A stimulus write is queued only when the enable bit is 1 and the port's mask bit is 1. Any other write is dropped and produces no line activity.
- R7: When several ports are written in the same cycle and all are accepted, the packets go out in ascending port order.
- R8: The ready flags are 1 while the 4-entry queue has a free entry and 0 when it is full. A write made while the queue is full is lost. When the queue has fewer free entries than same-cycle writes, only the lowest-numbered ports are accepted.
- R9: The serializer starts a packet only while the protocol register holds 2 (asynchronous NRZ). With any other value, packets stay queued and the line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational from cfg_addr) |
| stim_wr | input | NPORT | Per-port byte write strobe |
| stim_data | input | NPORT*8 | Per-port payload bytes, port i in bits [8i+7:8i] |
| stim_ready | output | NPORT | Per-port readiness: queue can accept a write |
| tx_out | output | 1 | Serial trace line, idle high |

## Verification
Two queue operations can happen in the same cycle. Several ports can push together, and those pushes can coincide with the serializer taking the head entry. The bench provokes simultaneous pushes by driving two port strobes in one cycle, both with the line running and with the serializer held off by the protocol register. With the serializer held off, three single writes are followed by a paired write, so exactly one entry is free when the pair arrives. The decoded line bytes are compared in order against a scoreboard queue, which shows both that the lower port goes first and that the upper port's byte is lost. The ready flags are checked after the fill.

// File: rtl/itrace_pkg.sv
package itrace_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
    localparam logic [1:0]  PROTO_NRZ  = 2'd2;
    localparam int          FRAME_BITS = 20;

    typedef enum logic [2:0] {
        REG_LOCK  = 3'd0,
        REG_CTRL  = 3'd1,
        REG_MASK  = 3'd2,
        REG_PRESC = 3'd3,
        REG_PROTO = 3'd4
    } reg_addr_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [4:0] port;
        logic [7:0] data;
    } pkt_t;

    // one-byte payload size code in the low bits, port number above
    function automatic logic [7:0] hdr_byte(input logic [4:0] port);
        return {port, 3'b001};
    endfunction

endpackage

// File: rtl/itrace_regs.sv
module itrace_regs
    import itrace_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [2:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               locked,
    output logic               enable,
    output logic [NPORT-1:0]   mask,
    output logic [PRESC_W-1:0] presc,
    output logic [1:0]         proto
);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
            enable <= 1'b0;
            mask   <= '0;
            presc  <= '0;
            proto  <= '0;
        end else if (we) begin
            if (reg_addr_e'(addr) == REG_LOCK) begin
                locked <= (wdata != UNLOCK_KEY);
            end else if (!locked) begin
                case (reg_addr_e'(addr))
                    REG_CTRL:  enable <= wdata[0];
                    REG_MASK:  mask   <= wdata[NPORT-1:0];
                    REG_PRESC: presc  <= wdata[PRESC_W-1:0];
                    REG_PROTO: proto  <= wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            REG_LOCK:  rdata[0]           = locked;
            REG_CTRL:  rdata[0]           = enable;
            REG_MASK:  rdata[NPORT-1:0]   = mask;
            REG_PRESC: rdata[PRESC_W-1:0] = presc;
            REG_PROTO: rdata[1:0]         = proto;
            default: ;
        endcase
    end

endmodule

// File: rtl/itrace_accept.sv
module itrace_accept #(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [NPORT-1:0] stim_wr,
    input  logic             enable,
    input  logic [NPORT-1:0] mask,
    input  logic [CW-1:0]    free,
    output logic [NPORT-1:0] accept
);

    logic [CW-1:0] taken;

    // lowest port claims free entries first
    always_comb begin
        taken  = '0;
        accept = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (stim_wr[i] && enable && mask[i] && (taken < free)) begin
                accept[i] = 1'b1;
                taken     = taken + CW'(1);
            end
        end
    end

endmodule

// File: rtl/itrace_fifo.sv
module itrace_fifo
    import itrace_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT-1:0]   push,
    input  logic [NPORT*8-1:0] push_data,
    input  logic               pop,
    output pkt_t               head,
    output logic [CW-1:0]      count
);

    pkt_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] slot [NPORT];
    logic [CW-1:0] npush;

    // each pushing port gets the next consecutive slot in port order
    always_comb begin
        npush = '0;
        for (int i = 0; i < NPORT; i++) begin
            slot[i] = wr_ptr + AW'(npush);
            if (push[i]) npush = npush + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORT; i++) begin
            if (push[i]) begin
                mem[slot[i]] <= '{port: 5'(i), data: push_data[i*8 +: 8]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(npush);
            if (pop) rd_ptr <= rd_ptr + AW'(1);
            count  <= count + npush - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/itrace_uart_tx.sv
module itrace_uart_tx
    import itrace_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_ok,
    input  logic               fifo_empty,
    input  pkt_t               head,
    input  logic [PRESC_W-1:0] presc,
    output logic               pop,
    output logic               busy,
    output logic               tx
);

    tx_state_e                 state;
    logic [FRAME_BITS-1:0]     shreg;
    logic [4:0]                bitn;
    logic [PRESC_W-1:0]        divcnt;

    assign pop  = (state == TX_IDLE) && !fifo_empty && run_ok;
    assign busy = (state == TX_SEND);
    assign tx   = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '1;
            bitn   <= '0;
            divcnt <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (pop) begin
                        // header frame in the low ten bits, payload frame above
                        shreg  <= {1'b1, head.data, 1'b0,
                                   1'b1, hdr_byte(head.port), 1'b0};
                        bitn   <= '0;
                        divcnt <= '0;
                        state  <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (divcnt >= presc) begin
                        divcnt <= '0;
                        shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
                        if (bitn == 5'(FRAME_BITS - 1)) begin
                            state <= TX_IDLE;
                        end else begin
                            bitn <= bitn + 5'd1;
                        end
                    end else begin
                        divcnt <= divcnt + PRESC_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/itrace_serializer.sv
module itrace_serializer
    import itrace_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int DEPTH   = 4,
    parameter int PRESC_W = 16,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NPORT-1:0]   stim_wr,
    input  logic [NPORT*8-1:0] stim_data,
    output logic [NPORT-1:0]   stim_ready,
    output logic               tx_out
);

    logic               locked;
    logic               cfg_enable;
    logic [NPORT-1:0]   mask;
    logic [PRESC_W-1:0] presc;
    logic [1:0]         proto;
    logic [NPORT-1:0]   accept;
    logic [CW-1:0]      fifo_count;
    logic [CW-1:0]      free;
    logic               fifo_pop;
    logic               tx_busy;
    pkt_t               head;

    itrace_regs #(.NPORT(NPORT), .PRESC_W(PRESC_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .locked(locked), .enable(cfg_enable), .mask(mask),
        .presc(presc), .proto(proto)
    );

    assign free       = CW'(DEPTH) - fifo_count;
    assign stim_ready = {NPORT{fifo_count < CW'(DEPTH)}};

    itrace_accept #(.NPORT(NPORT), .DEPTH(DEPTH)) u_accept (
        .stim_wr(stim_wr), .enable(cfg_enable), .mask(mask), .free(free),
        .accept(accept)
    );

    itrace_fifo #(.NPORT(NPORT), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(accept), .push_data(stim_data),
        .pop(fifo_pop), .head(head), .count(fifo_count)
    );

    itrace_uart_tx #(.PRESC_W(PRESC_W)) u_tx (
        .clk(clk), .rst(rst), .run_ok(proto == PROTO_NRZ),
        .fifo_empty(fifo_count == '0), .head(head), .presc(presc),
        .pop(fifo_pop), .busy(tx_busy), .tx(tx_out)
    );

endmodule

// File: rtl/itrace_checker.sv
module itrace_checker
    import itrace_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int DEPTH   = 4,
    parameter int PRESC_W = 16,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_out,
    input logic [NPORT-1:0]   stim_ready,
    input logic [CW-1:0]      fifo_count,
    input logic               fifo_pop,
    input logic               tx_busy,
    input logic               locked,
    input logic               cfg_enable,
    input logic [NPORT-1:0]   mask,
    input logic [PRESC_W-1:0] presc,
    input logic [1:0]         proto
);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= DEPTH);

    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (!stim_ready[0] && !fifo_pop) |=> $stable(fifo_count));

    a_r2_locked_hold: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(presc) && $stable(proto) && $stable(mask) && $stable(cfg_enable)));

    a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == '0 && !tx_busy) |=> tx_out);

    a_r9_proto_gate: assert property (@(posedge clk) disable iff (rst)
        (proto != PROTO_NRZ && !tx_busy) |=> !tx_busy);

endmodule

bind itrace_serializer itrace_checker #(
    .NPORT(NPORT), .DEPTH(DEPTH), .PRESC_W(PRESC_W)
) u_chk (
    .clk(clk), .rst(rst), .tx_out(tx_out), .stim_ready(stim_ready),
    .fifo_count(fifo_count), .fifo_pop(fifo_pop), .tx_busy(tx_busy),
    .locked(locked), .cfg_enable(cfg_enable), .mask(mask), .presc(presc),
    .proto(proto)
);

// File: tb/itrace_serializer_test.sv
module itrace_serializer_test;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [2:0]    cfg_addr;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic [NP-1:0] stim_wr;
    logic [NP*8-1:0] stim_data;
    logic [NP-1:0] stim_ready;
    logic          tx_out;

    int   checks = 0;
    int   errors = 0;
    int   bitlen = 1;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    itrace_serializer #(.NPORT(NP), .DEPTH(4), .PRESC_W(16)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stim_wr(stim_wr),
        .stim_data(stim_data), .stim_ready(stim_ready), .tx_out(tx_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] expv, input string req);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == expv, req, cfg_rdata, expv);
    endtask

    task automatic send(input int port, input logic [7:0] d, input bit expect_ok);
        @(negedge clk);
        stim_wr = '0;
        stim_wr[port] = 1'b1;
        stim_data[port*8 +: 8] = d;
        if (expect_ok) begin
            exp_q.push_back({5'(port), 3'b001});
            exp_q.push_back(d);
        end
        @(negedge clk);
        stim_wr = '0;
    endtask

    task automatic send_pair(input logic [7:0] d0, input logic [7:0] d1, input bit ok1);
        @(negedge clk);
        stim_wr = 4'b0011;
        stim_data[7:0]  = d0;
        stim_data[15:8] = d1;
        exp_q.push_back(8'h01); exp_q.push_back(d0);
        if (ok1) begin
            exp_q.push_back(8'h09); exp_q.push_back(d1);
        end
        @(negedge clk);
        stim_wr = '0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3 * bitlen + 5) @(negedge clk);
    endtask

    task automatic watch(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (tx_out !== 1'b1) lows++;
        end
    endtask

    // monitor: decode line bytes and compare against the scoreboard
    initial begin : monitor
        logic [7:0] b;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            while (tx_out !== 1'b0) @(negedge clk);
            repeat (bitlen / 2) @(negedge clk);
            chk(tx_out === 1'b0, "R5 start bit held to mid-bit", tx_out, 0);
            for (int k = 0; k < 8; k++) begin
                repeat (bitlen) @(negedge clk);
                b[k] = tx_out;
            end
            repeat (bitlen) @(negedge clk);
            chk(tx_out === 1'b1, "R4 stop bit high", tx_out, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected byte on line", b, 0);
            end else begin
                e = exp_q.pop_front();
                chk(b == e, "R3 R4 R7 line byte", b, e);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lows;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        stim_wr = '0; stim_data = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(tx_out === 1'b1, "R1 line idle high", tx_out, 1);
        chk(stim_ready == 4'hF, "R1 ports ready", stim_ready, 4'hF);
        rd_chk(3'd0, 32'd1, "R1 locked after reset");
        rd_chk(3'd3, 32'd0, "R1 prescaler zero");
        rd_chk(3'd4, 32'd0, "R1 protocol zero");

        // R2 lock behaviour
        cfg_write(3'd3, 32'd5);
        rd_chk(3'd3, 32'd0, "R2 write ignored while locked");
        cfg_write(3'd0, 32'hC5ACCE55);
        rd_chk(3'd0, 32'd0, "R2 unlocked by key");
        cfg_write(3'd3, 32'd3);
        bitlen = 4;
        rd_chk(3'd3, 32'd3, "R2 prescaler written when unlocked");
        cfg_write(3'd0, 32'h0);
        rd_chk(3'd0, 32'd1, "R2 relocked by wrong value");
        cfg_write(3'd3, 32'd9);
        rd_chk(3'd3, 32'd3, "R2 prescaler held after relock");
        cfg_write(3'd0, 32'hC5ACCE55);
        cfg_write(3'd4, 32'd2);
        cfg_write(3'd2, 32'h3);
        cfg_write(3'd1, 32'd1);
        rd_chk(3'd4, 32'd2, "R9 protocol set to NRZ");
        rd_chk(3'd2, 32'd3, "R6 mask readback");

        // R3 headers for port 0 and port 1
        send(0, 8'hA5, 1'b1);
        drain();
        send(1, 8'h3C, 1'b1);
        drain();

        // R7 same-cycle writes: port 0 first
        send_pair(8'h5A, 8'hC3, 1'b1);
        drain();

        // R6 masked port and disabled block drop writes
        send(2, 8'h11, 1'b0);
        watch(120, lows);
        chk(lows == 0, "R6 masked port no line activity", lows, 0);
        cfg_write(3'd1, 32'd0);
        send(0, 8'h22, 1'b0);
        watch(120, lows);
        chk(lows == 0, "R6 disabled block no line activity", lows, 0);
        cfg_write(3'd1, 32'd1);

        // R5 divide by one and an odd divider
        cfg_write(3'd3, 32'd0);
        bitlen = 1;
        send(1, 8'h81, 1'b1);
        drain();
        cfg_write(3'd3, 32'd6);
        bitlen = 7;
        send(0, 8'hF0, 1'b1);
        drain();

        // R8 / R9 fill the queue with the serializer held off
        cfg_write(3'd4, 32'd0);
        send(0, 8'h10, 1'b1);
        send(0, 8'h11, 1'b1);
        send(0, 8'h12, 1'b1);
        chk(stim_ready == 4'hF, "R8 ready with one free entry", stim_ready, 4'hF);
        send_pair(8'h13, 8'h77, 1'b0);
        chk(stim_ready == 4'h0, "R8 not ready when full", stim_ready, 0);
        send(0, 8'h99, 1'b0);
        chk(stim_ready == 4'h0, "R8 still full after lost write", stim_ready, 0);
        watch(200, lows);
        chk(lows == 0, "R9 line idle while protocol not NRZ", lows, 0);
        cfg_write(3'd4, 32'd2);
        drain();
        chk(stim_ready == 4'hF, "R8 ready after drain", stim_ready, 4'hF);
        chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

        watch(100, lows);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule